// File: doc/BRIEF.md
# Multi-Mode Timer with Polarity Control

This block is a 16-bit timer/counter with eight operating modes. A 3-bit mode field chooses among one-shot, continuous, input-edge counting, single-output PWM, capture, compare, input-gated counting and capture/compare. An enable bit starts and stops the timer. A single polarity bit has a different job in each mode: it sets the output level while the timer is stopped, it picks which input edge or level is active, and it picks the edge that arms capture/compare. The block has one external input pin, one output pin and a one-cycle interrupt pulse.

Software drives a single-cycle register write port to load the control word, the running count, the terminal (reload) value and the match value. The count, the last captured value and the enable state are always visible on outputs. The counter starts at 1. When it reaches its terminal value it returns to 1, which is called a reload event. The input pin is synchronized through a flop chain before any edge or level is used.

Top module: `mode_timer`

## Requirements
- R1: After reset the count is 1, the capture value is 0, the timer is disabled with polarity 0 and mode one-shot, the terminal value is all ones, and both the output pin and the interrupt are low.
- R2: A write with address 0 loads the control word: bit 0 is enable, bit 1 is polarity, and bits 4:2 are the mode (0 one-shot, 1 continuous, 2 counter, 3 PWM, 4 capture, 5 compare, 6 gated, 7 capture/compare). Address 1 loads the count, address 2 the terminal value and address 3 the match value. A count write takes precedence over counting in the same cycle.
- R3: While disabled, the count holds and the output pin is driven to the polarity value on the next clock, in every mode.
- R4: In one-shot, continuous, PWM, capture and compare modes the count advances once per clock while enabled. When a counting step finds the count equal to the terminal value, the count becomes 1 and the interrupt pulses. The terminal value is the match value in compare mode and the reload value in every other mode. Continuous mode keeps running after a reload event.
- R5: In one-shot mode a reload event clears the enable bit. The output pin is at the inverted polarity for exactly one cycle and then returns to the polarity value.
- R6: In every mode except PWM, the output pin toggles on each reload event while enabled.
- R7: In counter mode the count advances once per active input edge (rising for polarity 0, falling for polarity 1). The count changes on the third clock edge that samples the new input level.
- R8: In PWM mode, a counting step whose count equals the match value drives the output to the inverted polarity, and a reload event drives it to the polarity value. The reload event wins when both happen in the same step.
- R9: In capture mode an active input edge copies the current count into the capture value and pulses the interrupt.
- R10: In gated mode the count advances only while the synchronized input is at its active level (high for polarity 0, low for polarity 1). The interrupt pulses when the input leaves that level.
- R11: In capture/compare mode the count holds until the first active edge and then advances every clock. Each later opposite edge captures the count and pulses the interrupt. Disabling the timer or leaving the mode disarms it.
- R12: The interrupt is a registered signal that is high for one cycle per clock in which at least one event occurs, and it is never high without a reload, capture or gate-exit event in the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 count, 2 terminal, 3 match) |
| wr_data | input | 16 | Write data |
| tin | input | 1 | Timer input pin (asynchronous) |
| tout | output | 1 | Timer output pin |
| irq | output | 1 | One-cycle interrupt pulse |
| en_o | output | 1 | Current enable bit |
| cnt_o | output | 16 | Current count |
| cap_o | output | 16 | Last captured count |

## Verification
Most internal faults show at the ports within one or two clocks. A wrong count or terminal compare shows up on cnt_o in the next cycle and moves the reload interrupt and the output toggle. A wrong edge or level choice for the polarity bit shows three clocks after the input changes, as a count step or capture that is missing or comes at the wrong time. A stuck arm flag in capture/compare mode shows as a frozen count or a capture taken too early. The bench compares every output against a reference model on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    typedef enum logic [2:0] {
        MD_ONESHOT = 3'd0,
        MD_CONT    = 3'd1,
        MD_COUNTER = 3'd2,
        MD_PWM     = 3'd3,
        MD_CAPTURE = 3'd4,
        MD_COMPARE = 3'd5,
        MD_GATED   = 3'd6,
        MD_CAPCMP  = 3'd7
    } tmr_mode_e;

    // Packed so that bit 0 is enable, bit 1 polarity, bits 4:2 mode.
    typedef struct packed {
        tmr_mode_e mode;
        logic      pol;
        logic      en;
    } tmr_ctl_t;

    localparam int CTL_W  = $bits(tmr_ctl_t);
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT   = 2'd1;
    localparam logic [ADDR_W-1:0] A_TERM  = 2'd2;
    localparam logic [ADDR_W-1:0] A_MATCH = 2'd3;

    // Synchronized pin view: current level plus edges against the previous level.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_ev_t;

    // Modes that step once per clock while enabled.
    function automatic logic mode_free_run(tmr_mode_e m);
        return (m == MD_ONESHOT) || (m == MD_CONT) || (m == MD_PWM) ||
               (m == MD_CAPTURE) || (m == MD_COMPARE);
    endfunction

endpackage

// File: rtl/mtmr_sync_edge.sv
module mtmr_sync_edge
    import mtmr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pin,
    output pin_ev_t ev
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    always_comb begin
        ev.level = chain_q[STAGES-1];
        ev.rise  = chain_q[STAGES-1] & ~prev_q;
        ev.fall  = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              os_done,
    output tmr_ctl_t          ctl_q,
    output logic [CNT_W-1:0]  term_q,
    output logic [CNT_W-1:0]  match_q,
    output logic              cnt_wr
);
    logic ctl_wr;

    assign ctl_wr = wr_en && (wr_addr == A_CTL);
    assign cnt_wr = wr_en && (wr_addr == A_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{mode: MD_ONESHOT, pol: 1'b0, en: 1'b0};
        end else if (ctl_wr) begin
            ctl_q <= tmr_ctl_t'(wr_data[CTL_W-1:0]);
        end else if (os_done) begin
            ctl_q.en <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            term_q  <= '1;
            match_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_TERM)  term_q  <= wr_data;
            if (wr_addr == A_MATCH) match_q <= wr_data;
        end
    end
endmodule

// File: rtl/mtmr_core.sv
module mtmr_core
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctl_t         ctl,
    input  logic [CNT_W-1:0] term_val,
    input  logic [CNT_W-1:0] match_val,
    input  pin_ev_t          ev,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cap_q,
    output logic             irq_q,
    output logic             reload_ev,
    output logic             cap_ev,
    output logic             pwm_match,
    output logic             os_done,
    output logic             gate_act
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             armed_q;
    logic             act_edge;
    logic             opp_edge;
    logic             tick;
    logic             gate_exit;
    logic [CNT_W-1:0] limit;

    always_comb begin
        act_edge = ctl.pol ? ev.fall : ev.rise;
        opp_edge = ctl.pol ? ev.rise : ev.fall;
        gate_act = ev.level ^ ctl.pol;

        if (mode_free_run(ctl.mode)) begin
            tick = 1'b1;
        end else begin
            unique case (ctl.mode)
                MD_COUNTER: tick = act_edge;
                MD_GATED:   tick = gate_act;
                MD_CAPCMP:  tick = armed_q;
                default:    tick = 1'b0;
            endcase
        end
        tick = tick & ctl.en;

        limit     = (ctl.mode == MD_COMPARE) ? match_val : term_val;
        reload_ev = tick && (cnt_q == limit);
        pwm_match = tick && (ctl.mode == MD_PWM) && (cnt_q == match_val);
        os_done   = reload_ev && (ctl.mode == MD_ONESHOT);
        cap_ev    = ctl.en && (((ctl.mode == MD_CAPTURE) && act_edge) ||
                               ((ctl.mode == MD_CAPCMP) && armed_q && opp_edge));
        gate_exit = ctl.en && (ctl.mode == MD_GATED) && opp_edge;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ONE;
        end else if (cnt_wr) begin
            cnt_q <= cnt_wdata;
        end else if (reload_ev) begin
            cnt_q <= CNT_ONE;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (cap_ev) begin
            cap_q <= cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (!ctl.en || (ctl.mode != MD_CAPCMP)) begin
            armed_q <= 1'b0;
        end else if (act_edge) begin
            armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= reload_ev | cap_ev | gate_exit;
    end
endmodule

// File: rtl/mtmr_out.sv
module mtmr_out
    import mtmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_ctl_t ctl,
    input  logic     reload_ev,
    input  logic     pwm_match,
    output logic     tout_q
);
    logic tout_nxt;

    always_comb begin
        tout_nxt = tout_q;
        if (!ctl.en) begin
            tout_nxt = ctl.pol;
        end else if (ctl.mode == MD_PWM) begin
            if (reload_ev)      tout_nxt = ctl.pol;
            else if (pwm_match) tout_nxt = ~ctl.pol;
        end else if (reload_ev) begin
            tout_nxt = ~tout_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tout_q <= 1'b0;
        else     tout_q <= tout_nxt;
    end
endmodule

// File: rtl/mode_timer.sv
module mode_timer
    import mtmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tin,
    output logic              tout,
    output logic              irq,
    output logic              en_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cap_o
);
    tmr_ctl_t         ctl_q;
    logic [CNT_W-1:0] term_q;
    logic [CNT_W-1:0] match_q;
    logic             cnt_wr;
    pin_ev_t          pin_ev;
    logic             reload_ev;
    logic             cap_ev;
    logic             pwm_match;
    logic             os_done;
    logic             gate_act;

    mtmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (tin),
        .ev  (pin_ev)
    );

    mtmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .os_done (os_done),
        .ctl_q   (ctl_q),
        .term_q  (term_q),
        .match_q (match_q),
        .cnt_wr  (cnt_wr)
    );

    mtmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_q),
        .term_val  (term_q),
        .match_val (match_q),
        .ev        (pin_ev),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wr_data),
        .cnt_q     (cnt_o),
        .cap_q     (cap_o),
        .irq_q     (irq),
        .reload_ev (reload_ev),
        .cap_ev    (cap_ev),
        .pwm_match (pwm_match),
        .os_done   (os_done),
        .gate_act  (gate_act)
    );

    mtmr_out u_out (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_q),
        .reload_ev (reload_ev),
        .pwm_match (pwm_match),
        .tout_q    (tout)
    );

    assign en_o = ctl_q.en;
endmodule

// File: rtl/mode_timer_chk.sv
module mode_timer_chk
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input tmr_ctl_t         ctl,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cap,
    input logic             tout,
    input logic             irq,
    input logic             en_o,
    input logic             reload_ev,
    input logic             cap_ev,
    input logic             os_done,
    input logic             cnt_wr,
    input logic             ctl_wr,
    input logic             gate_act
);
    assert_idle_level_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl.en) |-> (tout == $past(ctl.pol)));

    assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctl.en) && !$past(cnt_wr)) |-> $stable(cnt));

    assert_reload_to_one_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(reload_ev) && !$past(cnt_wr)) |-> (cnt == CNT_W'(1)));

    assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(os_done) && !$past(ctl_wr)) |-> !en_o);

    assert_capture_value_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cap_ev) |-> (irq && (cap == $past(cnt))));

    assert_gate_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl.en) && ($past(ctl.mode) == MD_GATED) && !$past(gate_act) && !$past(cnt_wr))
        |-> $stable(cnt));

    assert_irq_cause_R12: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(reload_ev) || $past(cap_ev) || ($past(ctl.mode) == MD_GATED)));
endmodule

bind mode_timer mode_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl_q),
    .cnt       (cnt_o),
    .cap       (cap_o),
    .tout      (tout),
    .irq       (irq),
    .en_o      (en_o),
    .reload_ev (reload_ev),
    .cap_ev    (cap_ev),
    .os_done   (os_done),
    .cnt_wr    (cnt_wr),
    .ctl_wr    (wr_en && (wr_addr == 2'd0)),
    .gate_act  (gate_act)
);

// File: tb/mode_timer_bench.sv
module mode_timer_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        tin = 1'b0;
    logic        tout, irq, en_o;
    logic [15:0] cnt_o, cap_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic        m_s1, m_s2, m_prev, m_en, m_pol, m_armed, m_tout, m_irq;
    logic [2:0]  m_mode;
    logic [15:0] m_cnt, m_cap, m_rel, m_mat;

    always #(CLK_P/2) clk = ~clk;

    mode_timer u_mode_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tin(tin), .tout(tout), .irq(irq), .en_o(en_o), .cnt_o(cnt_o), .cap_o(cap_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string mode_req();
        if (!m_en) return "R3";
        case (m_mode)
            3'd0: return "R5";
            3'd1: return "R4";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R9";
            3'd5: return "R6";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic model_reset();
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_en = 0; m_pol = 0; m_armed = 0;
        m_tout = 0; m_irq = 0; m_mode = 3'd0; m_cnt = 16'd1; m_cap = 16'd0;
        m_rel = 16'hFFFF; m_mat = 16'd0;
    endtask

    task automatic model_step(input logic we, input logic [1:0] a, input logic [15:0] d, input logic ti);
        logic rise, fall, act, opp, tk, rl_ev, cap_ev, gx, pm, n_tout, n_armed, n_en;
        logic [15:0] term, n_cnt;
        rise = m_s2 & ~m_prev;
        fall = ~m_s2 & m_prev;
        act  = m_pol ? fall : rise;
        opp  = m_pol ? rise : fall;
        case (m_mode)
            3'd2:    tk = act;
            3'd6:    tk = m_s2 ^ m_pol;
            3'd7:    tk = m_armed;
            default: tk = 1'b1;
        endcase
        tk     = tk & m_en;
        term   = (m_mode == 3'd5) ? m_mat : m_rel;
        rl_ev  = tk && (m_cnt == term);
        cap_ev = m_en && (((m_mode == 3'd4) && act) || ((m_mode == 3'd7) && m_armed && opp));
        gx     = m_en && (m_mode == 3'd6) && opp;
        pm     = tk && (m_mode == 3'd3) && (m_cnt == m_mat);
        if (!m_en)              n_tout = m_pol;
        else if (m_mode == 3'd3) n_tout = rl_ev ? m_pol : (pm ? ~m_pol : m_tout);
        else                    n_tout = rl_ev ? ~m_tout : m_tout;
        if (we && a == 2'd1) n_cnt = d;
        else if (rl_ev)      n_cnt = 16'd1;
        else if (tk)         n_cnt = m_cnt + 16'd1;
        else                 n_cnt = m_cnt;
        n_armed = (!m_en || m_mode != 3'd7) ? 1'b0 : (act ? 1'b1 : m_armed);
        n_en = m_en;
        if (cap_ev) m_cap = m_cnt;
        if (we && a == 2'd0) begin
            n_en = d[0]; m_pol = d[1]; m_mode = d[4:2];
        end else if (rl_ev && m_mode == 3'd0) begin
            n_en = 1'b0;
        end
        if (we && a == 2'd2) m_rel = d;
        if (we && a == 2'd3) m_mat = d;
        m_en = n_en; m_cnt = n_cnt; m_tout = n_tout; m_armed = n_armed;
        m_irq = rl_ev | cap_ev | gx;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = ti;
    endtask

    task automatic compare_all();
        string r;
        r = mode_req();
        chk(r, "cnt", 32'(cnt_o), 32'(m_cnt));
        chk(r, "tout", 32'(tout), 32'(m_tout));
        chk("R12", "irq", 32'(irq), 32'(m_irq));
        chk("R9", "cap", 32'(cap_o), 32'(m_cap));
        chk("R5", "en", 32'(en_o), 32'(m_en));
    endtask

    task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d, input logic ti);
        wr_en = we; wr_addr = a; wr_data = d; tin = ti;
        @(posedge clk);
        model_step(we, a, d, ti);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [15:0] ctlw(input logic [2:0] mode, input logic pol, input logic en);
        return {11'd0, mode, pol, en};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic ti;
        void'($urandom(32'd1234));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        chk("R1", "cnt", 32'(cnt_o), 32'd1);
        chk("R1", "cap", 32'(cap_o), 32'd0);
        chk("R1", "en", 32'(en_o), 32'd0);
        chk("R1", "tout", 32'(tout), 32'd0);
        chk("R1", "irq", 32'(irq), 32'd0);

        // R7: counter-mode latency, polarity 0
        cyc(1, 2'd2, 16'd100, 0);
        cyc(1, 2'd0, ctlw(3'd2, 0, 1), 0);
        repeat (3) cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 1);
        chk("R7", "cnt after first sample", 32'(cnt_o), 32'd1);
        cyc(0, 0, 0, 1);
        chk("R7", "cnt after second sample", 32'(cnt_o), 32'd1);
        cyc(0, 0, 0, 1);
        chk("R7", "cnt after third sample", 32'(cnt_o), 32'd2);

        // R5: one-shot of length 3
        cyc(1, 2'd0, ctlw(3'd0, 0, 0), 0);
        cyc(1, 2'd2, 16'd3, 0);
        cyc(1, 2'd1, 16'd1, 0);
        cyc(1, 2'd0, ctlw(3'd0, 0, 1), 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        chk("R4", "cnt before reload", 32'(cnt_o), 32'd3);
        cyc(0, 0, 0, 0);
        chk("R5", "en cleared", 32'(en_o), 32'd0);
        chk("R5", "tout pulse", 32'(tout), 32'd1);
        chk("R12", "irq on reload", 32'(irq), 32'd1);
        cyc(0, 0, 0, 0);
        chk("R5", "tout back to polarity", 32'(tout), 32'd0);
        chk("R12", "irq single cycle", 32'(irq), 32'd0);

        // R2: count write wins over a counting step (continuous)
        cyc(1, 2'd2, 16'd50, 0);
        cyc(1, 2'd0, ctlw(3'd1, 0, 1), 0);
        cyc(0, 0, 0, 0);
        cyc(1, 2'd1, 16'd7, 0);
        chk("R2", "count write precedence", 32'(cnt_o), 32'd7);

        // R8: match equal to terminal keeps output at polarity
        cyc(1, 2'd0, ctlw(3'd3, 0, 0), 0);
        cyc(1, 2'd2, 16'd4, 0);
        cyc(1, 2'd3, 16'd4, 0);
        cyc(1, 2'd1, 16'd1, 0);
        cyc(1, 2'd0, ctlw(3'd3, 0, 1), 0);
        for (int i = 0; i < 10; i++) begin
            cyc(0, 0, 0, 0);
            chk("R8", "reload wins over match", 32'(tout), 32'd0);
        end

        // R6: compare mode toggles every 3 clocks with polarity 1
        cyc(1, 2'd0, ctlw(3'd5, 1, 0), 0);
        cyc(1, 2'd3, 16'd3, 0);
        cyc(1, 2'd1, 16'd1, 0);
        cyc(1, 2'd0, ctlw(3'd5, 1, 1), 0);
        chk("R3", "idle level before start", 32'(tout), 32'd1);
        repeat (3) cyc(0, 0, 0, 0);
        chk("R6", "toggle on reload", 32'(tout), 32'd0);

        // Constrained random segments, every cycle compared with the model
        ti = 1'b0;
        for (int seg = 0; seg < 70; seg++) begin
            logic [2:0]  md;
            logic        pl;
            logic [15:0] rl, mt;
            int          len;
            md  = 3'($urandom % 8);
            pl  = 1'($urandom % 2);
            rl  = 16'(1 + $urandom % 10);
            mt  = 16'(1 + $urandom % rl);
            len = 60 + int'($urandom % 100);
            cyc(1, 2'd0, ctlw(md, pl, 0), ti);
            cyc(1, 2'd2, rl, ti);
            cyc(1, 2'd3, mt, ti);
            cyc(1, 2'd1, 16'd1, ti);
            cyc(0, 0, 0, ti);
            cyc(1, 2'd0, ctlw(md, pl, 1), ti);
            for (int c = 0; c < len; c++) begin
                int sel;
                if ($urandom % 4 == 0) ti = ~ti;
                sel = int'($urandom % 100);
                if (sel == 0)      cyc(1, 2'd1, 16'($urandom % 8), ti);
                else if (sel == 1) cyc(1, 2'd0, ctlw(md, pl, 0), ti);
                else if (sel == 2) cyc(1, 2'd0, ctlw(md, pl, 1), ti);
                else               cyc(0, 0, 0, ti);
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule